// File: doc/BRIEF.md
# Shared Memory Bus Arbiter

This block decides, once per bus clock, which of three requesters owns a single shared memory bus: the display fetch engine, a block-transfer (blit) engine, or the CPU. Display fetch always takes the clocks assigned to it. The blit engine and the CPU share the remaining clocks. A CPU memory access takes two clocks. The first is a setup clock that the CPU never uses, so it stays free for DMA. The second is the clock in which the CPU owns the bus.

When a blit job is running, a priority control ("hog") selects between two policies. With hog clear, a CPU that has been refused the bus for three clocks in a row takes the next clock, even if the blit engine wants it. With hog set, the CPU gets no bus clock until the job ends.

A job is started by writing a size in words per channel together with a mask of the enabled channels. The block counts the bus accesses the job still needs and reports a busy flag. A size write that arrives while a job is running is ignored, and a one-clock error pulse reports it. All outputs are registered. The grant seen in a clock is the decision made from the inputs sampled at the preceding rising edge.

Top module: `membus_arbiter`

## Requirements
- R1: `grant` has bit 0 for display, bit 1 for blitter and bit 2 for CPU. At most one bit is high. It is all zero when no requester is eligible. It appears one clock after the inputs that caused it.
- R2: A display slot request is granted to display regardless of the blitter and CPU requests.
- R3: The first clock of a CPU request, counted after reset, after a CPU grant or after a clock without request, is a setup clock and is never granted. With no job running and no display slot, a CPU that requests continuously is granted every second clock.
- R4: With hog clear and a job running, a CPU refused on three consecutive eligible clocks is granted the next non-display clock ahead of the blitter. A CPU and blitter that both request continuously therefore give a repeating pattern of one CPU grant and four blitter grants.
- R5: Eligible CPU clocks lost to display slots count toward the three-clock refusal limit in the same way as clocks lost to the blitter.
- R6: With hog set, the CPU receives no grant while `blt_busy` is high, even if the blitter does not request.
- R7: An accepted size write starts a job of `size_words` times the number of set bits in `chan_en` accesses. `blt_busy` goes high in the next clock when that length is nonzero. It is low in the clock in which the final blitter grant appears.
- R8: A size write while `blt_busy` is high leaves the job unchanged and produces a `size_err` pulse exactly one clock long in the next clock.
- R9: `cpu_wait` is high in the clock after an eligible CPU clock that was not granted to the CPU, and low otherwise.
- R10: The blitter is granted only while `blt_busy` is high and `blt_req` is high. A zero-length job never makes the block busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| dsp_slot | input | 1 | Display fetch needs this clock |
| blt_req | input | 1 | Blit engine wants a bus access |
| cpu_req | input | 1 | CPU access request, held until granted |
| blt_hog | input | 1 | Lock the CPU out while a job runs |
| size_wr | input | 1 | Start a job with the size below |
| size_words | input | WORDS_W | Words per channel of the new job |
| chan_en | input | CHAN_N | Enabled-channel mask of the new job |
| grant | output | 3 | One-hot grant: bit0 display, bit1 blitter, bit2 CPU |
| cpu_wait | output | 1 | CPU was eligible and refused |
| blt_busy | output | 1 | Blit job has accesses left |
| size_err | output | 1 | Size write arrived while busy |

## Verification
The assertions check on every clock the properties that relate one decision to its inputs: the grant has at most one bit, display wins, the CPU is silent in setup clocks and under hog, a starved CPU is forced through, and the job counter steps down on each blitter grant and holds across a rejected write. Properties that only appear over a sequence need the bench's scenarios. These are the five-clock CPU and blitter rhythm, display slots advancing the starvation count, the exact clock busy drops after a computed job length, the every-other-clock CPU rate on an idle bus, and the one-clock error pulse.

// File: rtl/memarb_pkg.sv
package memarb_pkg;
  localparam int SRC_N   = 3;
  localparam int SRC_DSP = 0;
  localparam int SRC_BLT = 1;
  localparam int SRC_CPU = 2;
  typedef logic [SRC_N-1:0] grant_t;
endpackage

// File: rtl/blit_job_ctr.sv
module blit_job_ctr #(
  parameter int WORDS_W = 10,
  parameter int CHAN_N  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               size_wr,
  input  logic [WORDS_W-1:0] size_words,
  input  logic [CHAN_N-1:0]  chan_en,
  input  logic               blt_take,
  output logic               busy,
  output logic               size_err
);
  localparam int CNT_W = $clog2(CHAN_N + 1);
  localparam int REM_W = WORDS_W + CNT_W;

  logic [CNT_W-1:0] chan_cnt;
  logic [REM_W-1:0] job_len, rem_q, rem_nxt;
  logic             busy_q, err_q;

  always_comb begin
    chan_cnt = '0;
    for (int i = 0; i < CHAN_N; i++)
      chan_cnt = chan_cnt + CNT_W'(chan_en[i]);
  end

  assign job_len = REM_W'(size_words) * REM_W'(chan_cnt);

  always_comb begin
    rem_nxt = rem_q;
    if (size_wr && !busy_q)
      rem_nxt = job_len;
    else if (blt_take && rem_q != '0)
      rem_nxt = rem_q - REM_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      rem_q  <= rem_nxt;
      busy_q <= (rem_nxt != '0);
      err_q  <= size_wr && busy_q;
    end
  end

  assign busy     = busy_q;
  assign size_err = err_q;

  // R7
  load_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (size_wr && !busy && job_len != '0) |=> busy);
  // R7
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    blt_take |=> (rem_q == $past(rem_q) - REM_W'(1)));
  // R8
  wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (size_wr && busy && !blt_take) |=> (rem_q == $past(rem_q)));
  // R8
  err_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (size_wr && busy) |=> size_err);
  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(size_wr && busy) |=> !size_err);
  // R10
  take_busy_chk: assert property (@(posedge clk) disable iff (rst)
    blt_take |-> busy);
endmodule

// File: rtl/cpu_starve.sv
module cpu_starve #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_req,
  input  logic cpu_take,
  output logic elig,
  output logic starved
);
  localparam int CW = $clog2(LIMIT + 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;

  assign elig    = cpu_req && armed_q;
  assign starved = elig && (cnt_q >= CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= cpu_req && !cpu_take;
      if (!elig || cpu_take)
        cnt_q <= '0;
      else if (cnt_q < CW'(LIMIT))
        cnt_q <= cnt_q + CW'(1);
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(LIMIT));
  // R3
  setup_free_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_take |=> !elig);
endmodule

// File: rtl/grant_sel.sv
module grant_sel
  import memarb_pkg::*;
(
  input  logic   dsp_slot,
  input  logic   blt_req,
  input  logic   busy,
  input  logic   hog,
  input  logic   cpu_elig,
  input  logic   cpu_starved,
  output grant_t pick
);
  logic blt_ok, cpu_forced, cpu_ok;

  assign blt_ok     = busy && blt_req;
  assign cpu_forced = cpu_starved && busy && !hog;
  assign cpu_ok     = cpu_elig && !(busy && hog);

  always_comb begin
    pick = '0;
    if (dsp_slot)        pick[SRC_DSP] = 1'b1;
    else if (cpu_forced) pick[SRC_CPU] = 1'b1;
    else if (blt_ok)     pick[SRC_BLT] = 1'b1;
    else if (cpu_ok)     pick[SRC_CPU] = 1'b1;
  end
endmodule

// File: rtl/membus_arbiter.sv
module membus_arbiter
  import memarb_pkg::*;
#(
  parameter int WORDS_W    = 10,
  parameter int CHAN_N     = 4,
  parameter int STARVE_LIM = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dsp_slot,
  input  logic               blt_req,
  input  logic               cpu_req,
  input  logic               blt_hog,
  input  logic               size_wr,
  input  logic [WORDS_W-1:0] size_words,
  input  logic [CHAN_N-1:0]  chan_en,
  output logic [2:0]         grant,
  output logic               cpu_wait,
  output logic               blt_busy,
  output logic               size_err
);
  grant_t pick, grant_q;
  logic   cpu_elig, cpu_starved, wait_q;

  blit_job_ctr #(.WORDS_W(WORDS_W), .CHAN_N(CHAN_N)) u_job (
    .clk(clk), .rst(rst), .size_wr(size_wr), .size_words(size_words),
    .chan_en(chan_en), .blt_take(pick[SRC_BLT]),
    .busy(blt_busy), .size_err(size_err)
  );

  cpu_starve #(.LIMIT(STARVE_LIM)) u_starve (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_take(pick[SRC_CPU]),
    .elig(cpu_elig), .starved(cpu_starved)
  );

  grant_sel u_sel (
    .dsp_slot(dsp_slot), .blt_req(blt_req), .busy(blt_busy), .hog(blt_hog),
    .cpu_elig(cpu_elig), .cpu_starved(cpu_starved), .pick(pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      wait_q  <= 1'b0;
    end else begin
      grant_q <= pick;
      wait_q  <= cpu_elig && !pick[SRC_CPU];
    end
  end

  assign grant    = grant_q;
  assign cpu_wait = wait_q;

  // R1
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q));
  // R1
  idle_none_chk: assert property (@(posedge clk) disable iff (rst)
    (!dsp_slot && !(blt_req && blt_busy) && !cpu_req) |=> (grant_q == '0));
  // R2
  dsp_wins_chk: assert property (@(posedge clk) disable iff (rst)
    dsp_slot |=> grant_q[SRC_DSP]);
  // R3
  setup_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_elig) |=> !grant_q[SRC_CPU]);
  // R4
  forced_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    (!dsp_slot && blt_busy && !blt_hog && cpu_starved) |=> grant_q[SRC_CPU]);
  // R6
  hog_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (blt_hog && blt_busy) |=> !grant_q[SRC_CPU]);
  // R9
  wait_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_req |=> !cpu_wait);
endmodule

// File: tb/tb_membus_arbiter.sv
module tb_membus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] G_NONE = 3'b000;
  localparam logic [2:0] G_DSP  = 3'b001;
  localparam logic [2:0] G_BLT  = 3'b010;
  localparam logic [2:0] G_CPU  = 3'b100;
  // {dsp_slot, blt_req, cpu_req, expected grant}, no job running
  localparam logic [5:0] VEC [9] = '{
    {3'b000, G_NONE}, {3'b100, G_DSP}, {3'b001, G_NONE},
    {3'b001, G_CPU},  {3'b001, G_NONE}, {3'b101, G_DSP},
    {3'b001, G_CPU},  {3'b010, G_NONE}, {3'b110, G_DSP}
  };

  logic clk = 0, rst = 1;
  logic dsp_slot = 0, blt_req = 0, cpu_req = 0, blt_hog = 0, size_wr = 0;
  logic [9:0] size_words = '0;
  logic [3:0] chan_en = '0;
  logic [2:0] grant;
  logic cpu_wait, blt_busy, size_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  membus_arbiter dut (
    .clk(clk), .rst(rst), .dsp_slot(dsp_slot), .blt_req(blt_req),
    .cpu_req(cpu_req), .blt_hog(blt_hog), .size_wr(size_wr),
    .size_words(size_words), .chan_en(chan_en), .grant(grant),
    .cpu_wait(cpu_wait), .blt_busy(blt_busy), .size_err(size_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(input int words, input logic [3:0] mask, input bit exp_busy);
    size_wr = 1; size_words = 10'(words); chan_en = mask;
    tick();
    size_wr = 0;
    chk(blt_busy == exp_busy, "R7 busy after size write", blt_busy, exp_busy);
  endtask

  task automatic idle_reqs();
    blt_req = 0; cpu_req = 0; dsp_slot = 0;
    tick();
  endtask

  initial begin
    int nb;
    logic [2:0] exp;
    repeat (3) tick();
    chk(grant == G_NONE && !blt_busy && !size_err && !cpu_wait,
        "R1 reset state", grant, 0);
    rst = 0;

    // R1 R2 R3: vector walk with no job running
    for (int i = 0; i < 9; i++) begin
      {dsp_slot, blt_req, cpu_req} = VEC[i][5:3];
      tick();
      chk(grant == VEC[i][2:0], "R1/R2/R3 vector grant", grant, VEC[i][2:0]);
    end
    idle_reqs();

    // R4 R7 R9: five-clock rhythm, 16-access job
    load(4, 4'hF, 1);
    blt_req = 1; cpu_req = 1; nb = 0;
    for (int k = 1; k <= 20; k++) begin
      tick();
      exp = (k % 5 == 0) ? G_CPU : G_BLT;
      if (grant == G_BLT) nb++;
      chk(grant == exp, "R4 rhythm grant", grant, exp);
      chk(blt_busy == (nb < 16), "R7 busy tracks job", blt_busy, nb < 16);
      if (k == 1) chk(cpu_wait == 0, "R9 no wait in setup", cpu_wait, 0);
      if (k == 2) chk(cpu_wait == 1, "R9 wait when refused", cpu_wait, 1);
    end
    chk(nb == 16, "R7 job length", nb, 16);
    idle_reqs();

    // R5: display-lost clocks advance starvation
    load(2, 4'h3, 1);
    blt_req = 1; cpu_req = 1;
    for (int k = 1; k <= 7; k++) begin
      dsp_slot = (k == 2 || k == 3);
      tick();
      exp = (k == 2 || k == 3) ? G_DSP : (k == 5) ? G_CPU : G_BLT;
      chk(grant == exp, "R5 display counts toward limit", grant, exp);
    end
    chk(blt_busy == 0, "R7 busy low at last grant", blt_busy, 0);
    idle_reqs();

    // R6: hog locks the CPU out
    blt_hog = 1;
    load(2, 4'b0101, 1);
    blt_req = 1; cpu_req = 1;
    for (int k = 1; k <= 5; k++) begin
      tick();
      exp = (k == 5) ? G_CPU : G_BLT;
      chk(grant == exp, "R6 hog grant", grant, exp);
    end
    idle_reqs();
    load(1, 4'b0001, 1);
    cpu_req = 1;
    for (int k = 1; k <= 3; k++) begin
      tick();
      chk(grant == G_NONE, "R6/R10 hog without blit request", grant, G_NONE);
    end
    blt_req = 1;
    tick();
    chk(grant == G_BLT && !blt_busy, "R6 final blit access", grant, G_BLT);
    tick();
    chk(grant == G_CPU, "R6 CPU after job ends", grant, G_CPU);
    blt_hog = 0;
    idle_reqs();

    // R8: size write while busy is ignored
    load(3, 4'b0001, 1);
    chk(size_err == 0, "R8 no error on accepted write", size_err, 0);
    size_wr = 1; size_words = 10'd10; chan_en = 4'hF;
    tick();
    size_wr = 0;
    chk(size_err == 1, "R8 error pulse", size_err, 1);
    tick();
    chk(size_err == 0, "R8 pulse one clock", size_err, 0);
    blt_req = 1;
    for (int k = 1; k <= 4; k++) begin
      tick();
      exp = (k <= 3) ? G_BLT : G_NONE;
      chk(grant == exp, "R8 original length kept", grant, exp);
    end
    idle_reqs();

    // R10: zero-length job
    load(5, 4'b0000, 0);
    blt_req = 1;
    tick();
    chk(grant == G_NONE, "R10 no blit grant when idle", grant, G_NONE);
    idle_reqs();

    // R3 R9: natural CPU rate on an idle bus
    cpu_req = 1;
    for (int k = 1; k <= 6; k++) begin
      tick();
      exp = (k % 2 == 0) ? G_CPU : G_NONE;
      chk(grant == exp, "R3 natural rate", grant, exp);
      chk(cpu_wait == 0, "R9 no wait on idle bus", cpu_wait, 0);
    end
    idle_reqs();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule